// File: doc/BRIEF.md
# Test-Mode Selector with Supervision Timers

This block turns two test-control bits into one of four test states and uses the state for two purposes. First, it picks which internal digital signal is driven onto a system-clock observation output. The choices are half the core clock, the zero-crossing detector output, the switched-capacitor clock, and the mixer frequency. Second, it sets the lengths of two supervision timers. One is the power-up reset delay, which keeps the internal reset low for a while after the chip reset is released. The other is the transmit watchdog, which cuts transmission off when the transmit request stays high for too long.

Both timers count one common tick. The tick is a prescaled pulse taken from the core clock. States 0 and 1 use long terminal counts. States 2 and 3 use counts that are `SPEEDUP` times shorter, so a tester can exercise both timers in little time. In the normal state a test-input pin can skip both timers. A disable bit turns that pin function off, so the pin can be used for observation while the receiver runs normally. A change of the test bits is taken into the state register only on a tick, and it never restarts a timer that is already counting.

Top module: `test_mux_timers`

## Requirements
- R1: `mux_state` equals `sel_lo + 2*sel_hi`. While `rst_n` is low the value is loaded directly from the test bits.
- R2: Once reset is released, a new value on the test bits reaches `mux_state` only at a clock edge on which a tick occurs. A tick occurs every `TICK_DIV` clock edges, counted from reset release.
- R3: `sys_tst` carries the following signal in each state. State 0: a divide-by-two of `clk` that is 0 in reset and toggles on every edge after reset. State 1: `zc_in`. State 2: `scclk_in`. State 3: `mix_in`.
- R4: In states 2 and 3, `core_rst_n` goes high on the `RST_SHORT`-th tick after reset release and stays low before that tick.
- R5: In states 0 and 1, `core_rst_n` goes high on the `RST_SHORT*SPEEDUP`-th tick after reset release.
- R6: A rising edge of `tx_req` starts the transmit watchdog. At the limit-th tick after that edge, `tx_on` drops and `tx_expired` rises. The limit is `TXTO_SHORT` ticks in states 2 and 3 and `TXTO_SHORT*SPEEDUP` ticks in states 0 and 1.
- R7: After the watchdog expires, `tx_on` stays low while `tx_req` stays high. It is allowed again only after `tx_req` falls and then rises again.
- R8: In state 0, with `tst_in` high and `tst_in_dis` low, `core_rst_n` goes high at the first edge after reset release, and the transmit watchdog never expires.
- R9: `tst_in` has no effect when `tst_in_dis` is high or when the state is not 0.
- R10: A state change that happens while the watchdog is counting keeps the ticks already counted. From the tick where the new state takes effect, the new limit applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| sel_lo | input | 1 | Test-control bit, weight 1 |
| sel_hi | input | 1 | Test-control bit, weight 2 |
| tst_in | input | 1 | Test-input pin; bypasses the timers in state 0 |
| tst_in_dis | input | 1 | High disables the test-input function |
| zc_in | input | 1 | Zero-crossing detector output |
| scclk_in | input | 1 | Switched-capacitor clock |
| mix_in | input | 1 | Mixer frequency signal |
| tx_req | input | 1 | Transmit enable request |
| mux_state | output | 2 | Active test state |
| sys_tst | output | 1 | Selected system-clock observation signal |
| core_rst_n | output | 1 | Delayed internal reset, active low |
| tx_on | output | 1 | Transmit permitted |
| tx_expired | output | 1 | Transmit watchdog has expired |

## Verification
The bench resets the block into each of the four states in turn and measures the reset delay and the watchdog length to the exact edge. This separates the long settings from the short ones and confirms the tick phase. For the source selector, every combination of the three external sources is applied, with the unselected ones set opposite to the selected one, so a wrong route is detected. The test input is driven under three conditions: with the override set, in a non-normal state, and in state 0. Only the last may shorten anything. A state switch is made three ticks into a watchdog count, which separates "keeps its count" from "restarts" and from "switches early".

// File: rtl/tm_pkg.sv
// Shared types for the test-mode selector block.
package tm_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ZC     = 2'd1,
        ST_SC     = 2'd2,
        ST_MIX    = 2'd3
    } tm_state_e;

    // States whose upper bit is set use the shortened timer limits.
    function automatic logic is_fast(input tm_state_e s);
        return s[1];
    endfunction
endpackage

// File: rtl/tm_tick.sv
// Prescaler: emits a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 2. The phase restarts at reset, so the first tick
// comes on the DIV-th edge after reset release.
module tm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Free-running phase counter that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tm_decode.sv
// State register and observation-source selector.
// Loads the decoded test bits while in reset, and afterwards only on
// a tick. Routes one of four digital sources to sys_tst.
module tm_decode
    import tm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      sel_lo,
    input  logic      sel_hi,
    input  logic      zc_in,
    input  logic      scclk_in,
    input  logic      mix_in,
    output tm_state_e state,
    output logic      sys_tst
);
    tm_state_e state_q;
    logic      half_q;
    logic [3:0] src;

    // Capture the test state in reset, or on a tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) state_q <= tm_state_e'({sel_hi, sel_lo});
    end

    // Divide-by-two of the core clock for state 0.
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    assign src     = {mix_in, scclk_in, zc_in, half_q};
    assign sys_tst = src[state_q];
    assign state   = state_q;

    // R2: without a tick, the state holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));
endmodule

// File: rtl/tm_timer.sv
// One-shot tick timer with a sticky done flag.
// start clears it, force_done sets done at once, and freeze pauses
// counting. The limit is SHORT or LONG, chosen by fast, and is
// re-evaluated on every tick, so a limit change keeps the count.
module tm_timer #(
    parameter int SHORT = 2,
    parameter int LONG  = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    input  logic start,
    input  logic force_done,
    input  logic freeze,
    output logic done
);
    localparam int W = $clog2(LONG + 1);
    localparam logic [W-1:0] LIM_S = W'(SHORT);
    localparam logic [W-1:0] LIM_L = W'(LONG);

    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;
    logic         done_q;

    assign limit = fast ? LIM_S : LIM_L;

    // Count ticks until the active limit is reached, then latch done.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (force_done) begin
            done_q <= 1'b1;
        end else if (tick && !freeze && !done_q) begin
            if (cnt_q + 1'b1 >= limit) done_q <= 1'b1;
            else                       cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done = done_q;

    // R7: done is held until a restart.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !start |=> done_q);
    // R6: done rises only on a tick or a forced bypass.
    p_done_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(tick) || $past(force_done));
    // R5: the count never reaches the long limit.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < LIM_L);
endmodule

// File: rtl/test_mux_timers.sv
// Top of the test-mode selector. It decodes the test state, routes the
// observation source, and runs the reset-delay and transmit-watchdog
// timers from a shared tick. All inputs are taken to be synchronous to
// clk.
module test_mux_timers
    import tm_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int RST_SHORT  = 2,
    parameter int TXTO_SHORT = 5,
    parameter int SPEEDUP    = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_lo,
    input  logic       sel_hi,
    input  logic       tst_in,
    input  logic       tst_in_dis,
    input  logic       zc_in,
    input  logic       scclk_in,
    input  logic       mix_in,
    input  logic       tx_req,
    output logic [1:0] mux_state,
    output logic       sys_tst,
    output logic       core_rst_n,
    output logic       tx_on,
    output logic       tx_expired
);
    localparam int RST_LONG  = RST_SHORT * SPEEDUP;
    localparam int TXTO_LONG = TXTO_SHORT * SPEEDUP;

    logic      tick;
    tm_state_e state;
    logic      bypass;
    logic      rst_done;
    logic      tx_d;
    logic      tx_rise;

    tm_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tm_decode u_dec (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .sel_lo(sel_lo), .sel_hi(sel_hi),
        .zc_in(zc_in), .scclk_in(scclk_in), .mix_in(mix_in),
        .state(state), .sys_tst(sys_tst)
    );

    assign bypass = (state == ST_NORMAL) && tst_in && !tst_in_dis;

    // Previous transmit request, used to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_d <= 1'b0;
        else        tx_d <= tx_req;
    end
    assign tx_rise = tx_req && !tx_d;

    tm_timer #(.SHORT(RST_SHORT), .LONG(RST_LONG)) u_rst_dly (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fast(is_fast(state)),
        .start(1'b0), .force_done(bypass), .freeze(1'b0), .done(rst_done)
    );

    tm_timer #(.SHORT(TXTO_SHORT), .LONG(TXTO_LONG)) u_tx_wd (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fast(is_fast(state)),
        .start(tx_rise), .force_done(1'b0), .freeze(bypass || !tx_req),
        .done(tx_expired)
    );

    assign mux_state  = state;
    assign core_rst_n = rst_done;
    assign tx_on      = tx_req && !tx_expired && rst_done;

    // R8/R9: an early reset release needs a tick or a valid bypass.
    p_release_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) && !$past(tick) |->
            $past(mux_state) == 2'd0 && $past(tst_in) && !$past(tst_in_dis));
    // R8: while bypassed, the watchdog cannot newly expire.
    p_bypass_no_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass && !tx_expired |=> !tx_expired || $past(tx_rise));
endmodule

// File: tb/test_mux_timers_test.sv
module test_mux_timers_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_lo = 0, sel_hi = 0, tst_in = 0, tst_in_dis = 0;
    logic zc_in = 0, scclk_in = 0, mix_in = 0, tx_req = 0;
    logic [1:0] mux_state;
    logic sys_tst, core_rst_n, tx_on, tx_expired;
    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    test_mux_timers uut (
        .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .tst_in(tst_in), .tst_in_dis(tst_in_dis), .zc_in(zc_in),
        .scclk_in(scclk_in), .mix_in(mix_in), .tx_req(tx_req),
        .mux_state(mux_state), .sys_tst(sys_tst), .core_rst_n(core_rst_n),
        .tx_on(tx_on), .tx_expired(tx_expired)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cyc %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic do_reset(input int st, input logic ti, input logic dis);
        @(negedge clk);
        rst_n = 0; tx_req = 0;
        sel_lo = st[0]; sel_hi = st[1]; tst_in = ti; tst_in_dis = dis;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Watchdog run of T ticks starting at the current negedge, then the re-arm rule.
    task automatic tx_run(input int t);
        int e, x;
        tx_req = 1;
        e = cyc + 1;
        x = ((e / 4) + 1) * 4 + 4 * (t - 1);
        wait_cyc(x - 1);
        check("R6 tx_on before limit", tx_on, 1);
        wait_cyc(x);
        check("R6 tx_on at limit", tx_on, 0);
        check("R6 expired at limit", tx_expired, 1);
        repeat (9) @(negedge clk);
        check("R7 stays off while held", tx_on, 0);
        tx_req = 0;
        @(negedge clk);
        tx_req = 1;
        @(negedge clk);
        check("R7 re-armed on new rise", tx_on, 1);
        check("R7 expired cleared", tx_expired, 0);
        tx_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Sweep all four states: decode, reset delay, source, watchdog.
        for (int st = 0; st < 4; st++) begin
            int l;
            do_reset(st, 1'b0, 1'b0);
            check("R1 state decode", mux_state, st);
            l = (st >= 2) ? 2 : 512;
            wait_cyc(4 * l - 1);
            check(st >= 2 ? "R4 reset held" : "R5 reset held", core_rst_n, 0);
            wait_cyc(4 * l);
            check(st >= 2 ? "R4 reset released" : "R5 reset released", core_rst_n, 1);
            if (st == 0) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    check("R3 half clock", sys_tst, cyc % 2);
                end
            end else begin
                for (int p = 0; p < 8; p++) begin
                    @(negedge clk);
                    zc_in = p[0]; scclk_in = p[1]; mix_in = p[2];
                    #1;
                    check("R3 source select", sys_tst, p[st-1]);
                end
            end
            @(negedge clk);
            tx_run((st >= 2) ? 5 : 1280);
        end

        // R9: override set, no bypass in state 0.
        do_reset(0, 1'b1, 1'b1);
        wait_cyc(16);
        check("R9 override blocks bypass", core_rst_n, 0);
        // R9: test input ignored in state 2.
        do_reset(2, 1'b1, 1'b0);
        wait_cyc(7);
        check("R9 no bypass in state 2", core_rst_n, 0);
        wait_cyc(8);
        check("R9 normal short release", core_rst_n, 1);

        // R8: bypass in state 0.
        do_reset(0, 1'b1, 1'b0);
        wait_cyc(1);
        check("R8 bypass releases reset", core_rst_n, 1);
        tx_req = 1;
        repeat (5200) @(negedge clk);
        check("R8 tx never expires", tx_on, 1);
        check("R8 expired low", tx_expired, 0);
        tx_req = 0;

        // R2 and R10: switch 0 -> 2 after three counted ticks.
        do_reset(0, 1'b0, 1'b0);
        wait_cyc(2048);
        tx_req = 1;
        wait_cyc(2061);
        sel_hi = 1;
        wait_cyc(2063);
        check("R2 state waits for tick", mux_state, 0);
        wait_cyc(2064);
        check("R2 state at tick", mux_state, 2);
        wait_cyc(2067);
        check("R10 count kept", tx_on, 1);
        wait_cyc(2068);
        check("R10 expiry on fifth tick", tx_on, 0);
        tx_req = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule